// File: doc/BRIEF.md
# Lockable Timer and Watchdog Unit

This block combines a prescaled down-counting timer with a watchdog counter behind a byte-wide register port. Software programs a prescaler, a 16-bit timer reload value and a watchdog count. A configuration register picks the watchdog's count clock: either the prescaler output or the timer's expiry pulses. It also picks how the watchdog is serviced: any write to the service address, or only a write that carries a fixed key byte. Four sticky lock bits let software freeze each register group so that runaway code cannot disturb it. Once set, a lock bit stays set until reset.

The counters run on a slow time base, given as a one-cycle `slow_tick` enable at the bus clock. Writes to the prescaler, timer or watchdog count first land in shadow registers and set a pending flag. A transfer state machine then moves them to the counters over three slow ticks. Its states are `XF_IDLE`, `XF_ARM` and `XF_HOLD`:
- `XF_IDLE` goes to `XF_ARM` on a tick while any flag is pending.
- `XF_ARM` goes to `XF_HOLD` on a tick.
- `XF_HOLD` goes back to `XF_IDLE` on a tick, and that tick commits every pending value.

The watchdog has its own machine with states `WD_OFF`, `WD_COUNT` and `WD_TRIPPED`:
- A reload with a non-zero value moves it to `WD_COUNT`. A reload with zero moves it to `WD_OFF`.
- A count clock that takes the count from 1 to 0 moves it from `WD_COUNT` to `WD_TRIPPED`. This raises the interrupt pulse and the sticky error.

Top module: `twd_unit`

## Requirements
- R1: After reset the configuration reads 0x00, the prescaler reads 0x00, both timer bytes read 0xFF, the status register reads 0x00, and `t0_irq`, `wd_irq` and `wd_error` are low.
- R2: The register map is: address 0 configuration, 1 prescaler, 2 timer low byte, 3 timer high byte, 4 timer status, 5 watchdog count, 6 watchdog service. In the configuration register:
  - bit 0 locks the configuration register;
  - bit 1 locks the prescaler;
  - bit 2 locks the timer bytes and the timer status;
  - bit 3 locks the watchdog count;
  - bit 4 makes timer expiries the watchdog's count clock;
  - bit 5 turns on key-match servicing;
  - bits 7:6 read 0.

  A write can set a lock bit but never clear it. Only reset clears it.
- R3: While a register is unlocked, a write to it is stored and read back. While it is locked, a write is ignored: it changes no value and sets no pending flag.
- R4: Reading the configuration, prescaler or timer bytes while their lock is set returns 0x00. The status register stays readable.
- R5: Status bit 1 (busy) reads 1 from the cycle after a write to the prescaler, a timer byte or the watchdog count, and reads the OR of all pending flags.
- R6: With the transfer machine idle, a written value takes effect on the third slow tick after the write. Busy reads 1 after two ticks and 0 after the third.
- R7: With prescaler P and timer reload R, the timer expires once every (P+1)*(R+1) slow ticks after a commit. Each expiry sets status bit 0 and `t0_irq`, which stay set until software writes 1 to status bit 0.
- R8: With configuration bit 4 set, the watchdog decrements once per timer expiry instead of once per prescaler step.
- R9: With key-match off, any write to the service address reloads the watchdog from its committed count.
- R10: With key-match on, only a service write of 0x5C reloads the watchdog. Any other byte has no effect.
- R11: When the watchdog count reaches zero, `wd_irq` pulses for one cycle and `wd_error` goes high. `wd_error` stays high through later reloads until reset.
- R12: The watchdog count and service addresses are write-only and read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable marking each slow time-base period |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| t0_irq | output | 1 | Sticky timer expiry flag |
| wd_irq | output | 1 | One-cycle watchdog expiry pulse |
| wd_error | output | 1 | Sticky watchdog error, cleared only by reset |

## Verification
Read data is combinational. Register and busy results are therefore due in the cycle after the write edge. The bench drives every input on the falling edge and samples after it, so each result is read one edge after its cause. A pending value commits on the edge of the third tick. Timer and watchdog expiries register on the edge of the tick that causes them, and `wd_irq` drops one clock later. Ticks are issued one at a time under bench control. Each check is therefore placed after an exact count of ticks: one tick before the expected event, to see it absent, and on the tick itself, to see it present.

// File: rtl/twd_pkg.sv
package twd_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int T0_W   = 2 * BUS_W;
    localparam int WD_W   = BUS_W;
    localparam int N_LOCK = 4;

    localparam logic [ADDR_W-1:0] A_CFG = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRE = 3'd1;
    localparam logic [ADDR_W-1:0] A_T0L = 3'd2;
    localparam logic [ADDR_W-1:0] A_T0H = 3'd3;
    localparam logic [ADDR_W-1:0] A_CSR = 3'd4;
    localparam logic [ADDR_W-1:0] A_WDC = 3'd5;
    localparam logic [ADDR_W-1:0] A_SVC = 3'd6;

    localparam int CFG_LK_CFG = 0;
    localparam int CFG_LK_PRE = 1;
    localparam int CFG_LK_T0  = 2;
    localparam int CFG_LK_WDC = 3;
    localparam int CFG_WD_T0  = 4;
    localparam int CFG_MATCH  = 5;

    localparam int CSR_HIT  = 0;
    localparam int CSR_BUSY = 1;

    typedef enum logic [1:0] {XF_IDLE, XF_ARM, XF_HOLD} xfer_state_e;
    typedef enum logic [1:0] {WD_OFF, WD_COUNT, WD_TRIPPED} wd_state_e;

    typedef struct packed {
        logic wdc;
        logic t0;
        logic pre;
    } pend_t;
endpackage

// File: rtl/twd_regs.sv
module twd_regs
    import twd_pkg::*;
#(
    parameter logic [BUS_W-1:0] SVC_KEY = 8'h5C,
    parameter logic [T0_W-1:0]  T0_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              commit,
    input  logic              t0_hit,
    output logic              busy,
    output logic              commit_pre,
    output logic              commit_t0,
    output logic              commit_wd,
    output logic [BUS_W-1:0]  pre_sh,
    output logic [T0_W-1:0]   t0_sh,
    output logic [WD_W-1:0]   wdc_sh,
    output logic              sel_t0_clk,
    output logic              svc_req,
    output logic              t0_flag
);
    logic [BUS_W-1:0] cfg_q, cfg_n;
    pend_t            pend_q, pend_n;
    logic             lk_cfg, lk_pre, lk_t0, lk_wdc, match_mode;
    logic             wr_cfg, wr_pre, wr_t0l, wr_t0h, wr_csr, wr_wdc, wr_svc;
    logic             any_load_wr;

    assign lk_cfg     = cfg_q[CFG_LK_CFG];
    assign lk_pre     = cfg_q[CFG_LK_PRE];
    assign lk_t0      = cfg_q[CFG_LK_T0];
    assign lk_wdc     = cfg_q[CFG_LK_WDC];
    assign match_mode = cfg_q[CFG_MATCH];
    assign sel_t0_clk = cfg_q[CFG_WD_T0];

    // write decode with lock gating
    assign wr_cfg = bus_wr && (bus_addr == A_CFG) && !lk_cfg;
    assign wr_pre = bus_wr && (bus_addr == A_PRE) && !lk_pre;
    assign wr_t0l = bus_wr && (bus_addr == A_T0L) && !lk_t0;
    assign wr_t0h = bus_wr && (bus_addr == A_T0H) && !lk_t0;
    assign wr_csr = bus_wr && (bus_addr == A_CSR) && !lk_t0;
    assign wr_wdc = bus_wr && (bus_addr == A_WDC) && !lk_wdc;
    assign wr_svc = bus_wr && (bus_addr == A_SVC);
    assign any_load_wr = wr_pre || wr_t0l || wr_t0h || wr_wdc;

    assign svc_req = wr_svc && (!match_mode || (bus_wdata == SVC_KEY));

    // configuration: lock bits only accumulate
    always_comb begin
        cfg_n = cfg_q;
        if (wr_cfg) begin
            cfg_n[N_LOCK-1:0] = cfg_q[N_LOCK-1:0] | bus_wdata[N_LOCK-1:0];
            cfg_n[CFG_WD_T0]  = bus_wdata[CFG_WD_T0];
            cfg_n[CFG_MATCH]  = bus_wdata[CFG_MATCH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_n;
    end

    // shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_sh <= '0;
            t0_sh  <= T0_INIT;
            wdc_sh <= '0;
        end else begin
            if (wr_pre) pre_sh <= bus_wdata;
            if (wr_t0l) t0_sh[BUS_W-1:0] <= bus_wdata;
            if (wr_t0h) t0_sh[T0_W-1:BUS_W] <= bus_wdata;
            if (wr_wdc) wdc_sh <= bus_wdata;
        end
    end

    // pending flags: cleared by the commit handshake, set by a new write
    always_comb begin
        pend_n = pend_q;
        if (commit) pend_n = '0;
        if (wr_pre) pend_n.pre = 1'b1;
        if (wr_t0l || wr_t0h) pend_n.t0 = 1'b1;
        if (wr_wdc) pend_n.wdc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_n;
    end

    assign busy       = |pend_q;
    assign commit_pre = commit && pend_q.pre;
    assign commit_t0  = commit && pend_q.t0;
    assign commit_wd  = commit && pend_q.wdc;

    // timer expiry flag, write-one-to-clear, set has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               t0_flag <= 1'b0;
        else if (t0_hit)                          t0_flag <= 1'b1;
        else if (wr_csr && bus_wdata[CSR_HIT])    t0_flag <= 1'b0;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG: if (!lk_cfg) bus_rdata = cfg_q;
            A_PRE: if (!lk_pre) bus_rdata = pre_sh;
            A_T0L: if (!lk_t0)  bus_rdata = t0_sh[BUS_W-1:0];
            A_T0H: if (!lk_t0)  bus_rdata = t0_sh[T0_W-1:BUS_W];
            A_CSR: begin
                bus_rdata[CSR_HIT]  = t0_flag;
                bus_rdata[CSR_BUSY] = busy;
            end
            default: bus_rdata = '0;
        endcase
    end

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_q[N_LOCK-1:0] & $past(cfg_q[N_LOCK-1:0])) == $past(cfg_q[N_LOCK-1:0])));

    assert_locked_pre_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_PRE) && lk_pre) |=> $stable(pre_sh));

    assert_locked_wdc_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_WDC) && lk_wdc) |=> $stable(wdc_sh));

    assert_pending_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !any_load_wr) |=> !busy);
endmodule

// File: rtl/twd_xfer.sv
module twd_xfer
    import twd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic busy,
    output logic commit
);
    xfer_state_e state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            XF_IDLE: if (tick && busy) state_n = XF_ARM;
            XF_ARM:  if (tick)         state_n = XF_HOLD;
            XF_HOLD: if (tick)         state_n = XF_IDLE;
            default:                   state_n = XF_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            XF_IDLE: commit = 1'b0;
            XF_ARM:  commit = 1'b0;
            XF_HOLD: commit = tick;
            default: commit = 1'b0;
        endcase
    end

    assert_commit_has_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);
endmodule

// File: rtl/twd_timebase.sv
module twd_timebase
    import twd_pkg::*;
#(
    parameter logic [T0_W-1:0] T0_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             commit_pre,
    input  logic [BUS_W-1:0] pre_sh,
    input  logic             commit_t0,
    input  logic [T0_W-1:0]  t0_sh,
    output logic             step,
    output logic             t0_hit
);
    logic [BUS_W-1:0] pre_rl, pcnt;
    logic [T0_W-1:0]  t0_rl, t0cnt;

    assign step   = tick && (pcnt == '0);
    assign t0_hit = step && (t0cnt == '0) && !commit_t0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_rl <= '0;
            pcnt   <= '0;
        end else if (commit_pre) begin
            pre_rl <= pre_sh;
            pcnt   <= pre_sh;
        end else if (tick) begin
            pcnt <= (pcnt == '0) ? pre_rl : pcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t0_rl <= T0_INIT;
            t0cnt <= T0_INIT;
        end else if (commit_t0) begin
            t0_rl <= t0_sh;
            t0cnt <= t0_sh;
        end else if (step) begin
            t0cnt <= (t0cnt == '0) ? t0_rl : t0cnt - 1'b1;
        end
    end

    assert_hit_needs_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        t0_hit |-> tick);
endmodule

// File: rtl/twd_watchdog.sv
module twd_watchdog
    import twd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            t0_hit,
    input  logic            sel_t0_clk,
    input  logic            commit_wd,
    input  logic [WD_W-1:0] wdc_sh,
    input  logic            svc_req,
    output logic            wd_irq,
    output logic            wd_error
);
    wd_state_e       st_q, st_n;
    logic [WD_W-1:0] rl_q, cnt_q, cnt_n, load_val;
    logic            wd_clk, reload, expire;

    assign wd_clk   = sel_t0_clk ? t0_hit : step;
    assign reload   = commit_wd || svc_req;
    assign load_val = commit_wd ? wdc_sh : rl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_OFF;
            cnt_q <= '0;
            rl_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            if (commit_wd) rl_q <= wdc_sh;
        end
    end

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        expire = 1'b0;
        unique case (st_q)
            WD_OFF, WD_TRIPPED: begin
                if (reload && (load_val != '0)) begin
                    st_n  = WD_COUNT;
                    cnt_n = load_val;
                end
            end
            WD_COUNT: begin
                if (reload) begin
                    cnt_n = load_val;
                    st_n  = (load_val == '0) ? WD_OFF : WD_COUNT;
                end else if (wd_clk) begin
                    cnt_n = cnt_q - 1'b1;
                    if (cnt_q == WD_W'(1)) begin
                        expire = 1'b1;
                        st_n   = WD_TRIPPED;
                    end
                end
            end
            default: st_n = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_irq   <= 1'b0;
            wd_error <= 1'b0;
        end else begin
            wd_irq   <= expire;
            wd_error <= wd_error || expire;
        end
    end

    assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wd_error |=> wd_error);

    assert_irq_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |=> !wd_irq);

    assert_irq_with_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> wd_error);
endmodule

// File: rtl/twd_unit.sv
module twd_unit
    import twd_pkg::*;
#(
    parameter logic [BUS_W-1:0] SVC_KEY = 8'h5C,
    parameter logic [T0_W-1:0]  T0_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              t0_irq,
    output logic              wd_irq,
    output logic              wd_error
);
    logic             busy, commit, commit_pre, commit_t0, commit_wd;
    logic [BUS_W-1:0] pre_sh;
    logic [T0_W-1:0]  t0_sh;
    logic [WD_W-1:0]  wdc_sh;
    logic             sel_t0_clk, svc_req, step, t0_hit;

    twd_regs #(.SVC_KEY(SVC_KEY), .T0_INIT(T0_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .commit(commit),
        .t0_hit(t0_hit), .busy(busy), .commit_pre(commit_pre),
        .commit_t0(commit_t0), .commit_wd(commit_wd), .pre_sh(pre_sh),
        .t0_sh(t0_sh), .wdc_sh(wdc_sh), .sel_t0_clk(sel_t0_clk),
        .svc_req(svc_req), .t0_flag(t0_irq)
    );

    twd_xfer u_xfer (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .busy(busy), .commit(commit)
    );

    twd_timebase #(.T0_INIT(T0_INIT)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .commit_pre(commit_pre),
        .pre_sh(pre_sh), .commit_t0(commit_t0), .t0_sh(t0_sh),
        .step(step), .t0_hit(t0_hit)
    );

    twd_watchdog u_wd (
        .clk(clk), .rst_n(rst_n), .step(step), .t0_hit(t0_hit),
        .sel_t0_clk(sel_t0_clk), .commit_wd(commit_wd), .wdc_sh(wdc_sh),
        .svc_req(svc_req), .wd_irq(wd_irq), .wd_error(wd_error)
    );
endmodule

// File: tb/twd_unit_tb_top.sv
module twd_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 20000;
    localparam int  NVEC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       t0_irq, wd_irq, wd_error;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic       wr;
        logic [2:0] addr;
        logic [7:0] wdata;
        logic [1:0] nt;
        logic [2:0] raddr;
        logic [7:0] rexp;
        logic [3:0] req;
    } vec_t;

    // address map: 0 cfg, 1 prescaler, 2 timer lo, 3 timer hi, 4 status, 5 wd count, 6 service
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 3'd1, 8'h12, 2'd0, 3'd1, 8'h12, 4'd3},  // R3 unlocked write stored
        '{1'b0, 3'd0, 8'h00, 2'd2, 3'd4, 8'h02, 4'd5},  // R5 busy after two ticks
        '{1'b0, 3'd0, 8'h00, 2'd1, 3'd4, 8'h00, 4'd6},  // R6 third tick commits
        '{1'b1, 3'd2, 8'h34, 2'd0, 3'd2, 8'h34, 4'd3},  // R3
        '{1'b1, 3'd3, 8'h56, 2'd3, 3'd3, 8'h56, 4'd3},  // R3
        '{1'b1, 3'd0, 8'h02, 2'd0, 3'd0, 8'h02, 4'd2},  // R2 lock prescaler
        '{1'b1, 3'd1, 8'h99, 2'd0, 3'd4, 8'h00, 4'd3},  // R3 locked write sets no pending
        '{1'b1, 3'd0, 8'h00, 2'd0, 3'd0, 8'h02, 4'd2},  // R2 lock bit sticky
        '{1'b0, 3'd0, 8'h00, 2'd0, 3'd1, 8'h00, 4'd4},  // R4 locked read
        '{1'b1, 3'd0, 8'h04, 2'd0, 3'd0, 8'h06, 4'd2},  // R2 lock timer
        '{1'b1, 3'd2, 8'h77, 2'd0, 3'd4, 8'h00, 4'd3},  // R3
        '{1'b0, 3'd0, 8'h00, 2'd0, 3'd3, 8'h00, 4'd4},  // R4
        '{1'b1, 3'd5, 8'h05, 2'd0, 3'd4, 8'h02, 4'd5},  // R5 wd count pending
        '{1'b0, 3'd0, 8'h00, 2'd0, 3'd5, 8'h00, 4'd12}, // R12 write-only
        '{1'b0, 3'd0, 8'h00, 2'd3, 3'd4, 8'h00, 4'd6},  // R6
        '{1'b1, 3'd0, 8'h08, 2'd0, 3'd0, 8'h0E, 4'd2},  // R2 lock wd count
        '{1'b1, 3'd5, 8'h07, 2'd0, 3'd4, 8'h00, 4'd3},  // R3
        '{1'b1, 3'd0, 8'hF0, 2'd0, 3'd0, 8'h3E, 4'd2},  // R2 reserved bits read 0
        '{1'b1, 3'd0, 8'h01, 2'd0, 3'd0, 8'h00, 4'd4},  // R4 cfg locked
        '{1'b1, 3'd6, 8'h5C, 2'd0, 3'd6, 8'h00, 4'd12}  // R12
    };

    twd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .t0_irq(t0_irq), .wd_irq(wd_irq), .wd_error(wd_error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG_CYCLES && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            slow_tick = 1'b1;
            cyc();
            slow_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    initial begin
        logic [7:0] d;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(3'd0, d); check(1, d, 8'h00, "cfg reset");
        rd(3'd1, d); check(1, d, 8'h00, "prescaler reset");
        rd(3'd2, d); check(1, d, 8'hFF, "timer lo reset");
        rd(3'd3, d); check(1, d, 8'hFF, "timer hi reset");
        rd(3'd4, d); check(1, d, 8'h00, "status reset");
        check(1, {5'd0, t0_irq, wd_irq, wd_error}, 8'h00, "outputs reset");

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].wdata);
            tick(int'(VEC[i].nt));
            rd(VEC[i].raddr, d);
            check(int'(VEC[i].req), d, VEC[i].rexp, $sformatf("vector %0d", i));
        end

        // R9 / R11: plain service, expiry pulse and sticky error
        do_reset();
        wr(3'd5, 8'h03);
        tick(3);
        tick(2);
        check(11, {7'd0, wd_error}, 8'h00, "no error before zero");
        wr(3'd6, 8'hA7);
        tick(2);
        check(9, {7'd0, wd_error}, 8'h00, "any-byte service reloaded");
        tick(1);
        check(11, {7'd0, wd_irq}, 8'h01, "irq on expiry");
        check(11, {7'd0, wd_error}, 8'h01, "error on expiry");
        cyc();
        check(11, {7'd0, wd_irq}, 8'h00, "irq one cycle");
        wr(3'd6, 8'h00);
        check(11, {7'd0, wd_error}, 8'h01, "error sticky over reload");
        wr(3'd0, 8'h0F);
        do_reset();
        check(11, {7'd0, wd_error}, 8'h00, "reset clears error");
        rd(3'd0, d); check(2, d, 8'h00, "reset clears locks");

        // R10: key-match servicing
        wr(3'd0, 8'h20);
        wr(3'd5, 8'h04);
        tick(3);
        tick(2);
        wr(3'd6, 8'h5C);
        tick(3);
        check(10, {7'd0, wd_error}, 8'h00, "key byte reloaded");
        wr(3'd6, 8'h11);
        tick(1);
        check(10, {7'd0, wd_error}, 8'h01, "wrong byte ignored");

        // R8: watchdog clocked by timer expiries
        do_reset();
        wr(3'd0, 8'h10);
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h00);
        wr(3'd5, 8'h02);
        tick(3);
        tick(3);
        check(8, {7'd0, wd_error}, 8'h00, "slow wd clock not yet expired");
        tick(1);
        check(8, {7'd0, wd_error}, 8'h01, "expired on second timer hit");

        // R7: timer period and write-one-to-clear flag
        do_reset();
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h00);
        tick(3);
        tick(5);
        check(7, {7'd0, t0_irq}, 8'h00, "no hit before period");
        tick(1);
        check(7, {7'd0, t0_irq}, 8'h01, "hit at period");
        rd(3'd4, d); check(7, d, 8'h01, "status hit bit");
        wr(3'd4, 8'h01);
        check(7, {7'd0, t0_irq}, 8'h00, "flag cleared");
        tick(5);
        check(7, {7'd0, t0_irq}, 8'h00, "second period not reached");
        tick(1);
        check(7, {7'd0, t0_irq}, 8'h01, "second hit");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule